// File: doc/BRIEF.md
# Stamping Press Sequence Controller

This block runs one press ram through an automatic stamping cycle. It reads six clean, synchronous operator and machine signals: an Auto button, a Stop button, a Reset button, a part-present sensor, and limit switches at the bottom and top of the ram's travel. From these it drives four outputs: the auto-mode lamp, the part clamp, the raise solenoid and the lower solenoid. The state is held in a small register. Each output is decoded from that state alone, so an input change reaches the outputs only after the clock edge that moves the state.

An operator arms the press with Auto. Each detected part then starts one stroke: the ram goes down to the bottom switch and back up to the top switch. The press then waits until the finished part has been taken away, so the next stroke needs a fresh part. Stop works only while the ram is travelling down. It parks the press with every output off. From there the operator must press Reset to reach idle and then press Auto again. A parameter can add a register stage after the output decode.

Top module: `press_seq_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the controller goes to idle. After that edge all four outputs read low. This also applies in the middle of a stroke.
- R2: In idle all outputs are low. Auto moves the controller to armed, where only `auto_lamp` is high. In idle every input other than Auto has no effect.
- R3: In armed, a high `part_sense` starts the down stroke. The down stroke drives `auto_lamp`, `part_hold` and `sol_down` high and `sol_up` low. In armed, the stop, reset and limit inputs have no effect.
- R4: In the down stroke, a high `bottom_ls` (with Stop low) starts the retract. The retract drives `auto_lamp`, `part_hold` and `sol_up` high and `sol_down` low.
- R5: In the retract, a high `top_ls` moves the controller to the removal wait. There only `auto_lamp` is high, so the clamp and the raise solenoid are released.
- R6: The removal wait lasts while `part_sense` stays high. The first cycle with `part_sense` low returns the controller to armed.
- R7: Stop takes effect only in the down stroke, where it moves the controller to stopped with all outputs low. If Stop and `bottom_ls` are high in the same cycle, Stop wins. In any other state Stop has no effect.
- R8: In stopped, Auto and all other inputs have no effect until `reset_btn` is high. Reset then moves the controller to idle, and a later Auto arms it again.
- R9: `sol_up` and `sol_down` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to idle, active high |
| auto_btn | input | 1 | Auto mode request |
| stop_btn | input | 1 | Stop request, acted on only during the down stroke |
| reset_btn | input | 1 | Clears the stopped state back to idle |
| part_sense | input | 1 | High when a part sits in the die |
| bottom_ls | input | 1 | Ram at bottom of travel |
| top_ls | input | 1 | Ram at top of travel |
| auto_lamp | output | 1 | Auto mode indicator |
| part_hold | output | 1 | Part clamp |
| sol_up | output | 1 | Raise solenoid |
| sol_down | output | 1 | Lower solenoid |

## Verification
The hardest case to reach is the stopped state, and within it the inputs that must be ignored. To get there, the ram must first be armed, loaded and moving down, and only then can Stop act. Stopped and idle also look the same at the outputs, so the bench tells them apart by pressing Auto and checking that the lamp stays off. Directed steps also raise Stop and the bottom switch in the same cycle. Random stimulus then draws each input with a moderate probability, which walks the sequence through all six states many times, with Stop arriving in every state and an occasional reset in the middle of a stroke.

// File: rtl/press_pkg.sv
package press_pkg;

   localparam int PRESS_STATES = 6;
   localparam int PRESS_SW     = $clog2(PRESS_STATES);

   typedef enum logic [PRESS_SW-1:0] {
      PS_IDLE  = 3'd0,
      PS_ARMED = 3'd1,
      PS_DOWN  = 3'd2,
      PS_RISE  = 3'd3,
      PS_HALT  = 3'd4,
      PS_WAIT  = 3'd5
   } press_state_t;

   typedef struct packed {
      logic lamp;
      logic hold;
      logic up;
      logic dn;
   } press_out_t;

   localparam int PRESS_OW = $bits(press_out_t);

endpackage

// File: rtl/press_next_state.sv
module press_next_state
   import press_pkg::*;
(
   input  press_state_t cur,
   input  logic         auto_btn,
   input  logic         stop_btn,
   input  logic         reset_btn,
   input  logic         part_sense,
   input  logic         bottom_ls,
   input  logic         top_ls,
   output press_state_t nxt
);

   always_comb begin
      nxt = cur;
      unique case (cur)
         PS_IDLE:  if (auto_btn)    nxt = PS_ARMED;
         PS_ARMED: if (part_sense)  nxt = PS_DOWN;
         PS_DOWN: begin
            if (stop_btn)           nxt = PS_HALT;
            else if (bottom_ls)     nxt = PS_RISE;
         end
         PS_RISE:  if (top_ls)      nxt = PS_WAIT;
         PS_WAIT:  if (!part_sense) nxt = PS_ARMED;
         PS_HALT:  if (reset_btn)   nxt = PS_IDLE;
         default:                   nxt = PS_IDLE;
      endcase
   end

endmodule

// File: rtl/press_out_decode.sv
module press_out_decode
   import press_pkg::*;
(
   input  press_state_t cur,
   output press_out_t   outs
);

   always_comb begin
      outs = '0;
      case (cur)
         PS_ARMED: outs.lamp = 1'b1;
         PS_DOWN: begin
            outs.lamp = 1'b1;
            outs.hold = 1'b1;
            outs.dn   = 1'b1;
         end
         PS_RISE: begin
            outs.lamp = 1'b1;
            outs.hold = 1'b1;
            outs.up   = 1'b1;
         end
         PS_WAIT:  outs.lamp = 1'b1;
         default:  outs = '0;
      endcase
   end

endmodule

// File: rtl/press_seq_ctrl.sv
module press_seq_ctrl
   import press_pkg::*;
#(
   parameter int OUT_REG = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic auto_btn,
   input  logic stop_btn,
   input  logic reset_btn,
   input  logic part_sense,
   input  logic bottom_ls,
   input  logic top_ls,
   output logic auto_lamp,
   output logic part_hold,
   output logic sol_up,
   output logic sol_down
);

   localparam bit REG_OUTS = (OUT_REG != 0);

   generate
      if (OUT_REG < 0 || OUT_REG > 1) begin : g_bad_param
         $error("press_seq_ctrl: OUT_REG must be 0 or 1");
      end
   endgenerate

   press_state_t cur_q, nxt;
   press_out_t   dec, outs;

   press_next_state u_next (
      .cur        (cur_q),
      .auto_btn   (auto_btn),
      .stop_btn   (stop_btn),
      .reset_btn  (reset_btn),
      .part_sense (part_sense),
      .bottom_ls  (bottom_ls),
      .top_ls     (top_ls),
      .nxt        (nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) cur_q <= PS_IDLE;
      else     cur_q <= nxt;
   end

   press_out_decode u_dec (
      .cur  (cur_q),
      .outs (dec)
   );

   generate
      if (REG_OUTS) begin : g_reg_out
         press_out_t outs_q;
         always_ff @(posedge clk) begin
            if (rst) outs_q <= '0;
            else     outs_q <= dec;
         end
         assign outs = outs_q;
      end else begin : g_comb_out
         assign outs = dec;
      end
   endgenerate

   assign auto_lamp = outs.lamp;
   assign part_hold = outs.hold;
   assign sol_up    = outs.up;
   assign sol_down  = outs.dn;

   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> cur_q == PS_IDLE);

   // R9
   no_dual_sol_chk: assert property (@(posedge clk) disable iff (rst)
      !(sol_up && sol_down));

   // R7
   stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_q == PS_DOWN && stop_btn) |=> cur_q == PS_HALT);

   // R8
   halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_q == PS_HALT && !reset_btn) |=> cur_q == PS_HALT);

   // R6
   wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_q == PS_WAIT && part_sense) |=> cur_q == PS_WAIT);

endmodule

// File: tb/press_seq_ctrl_tb.sv
module press_seq_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RAND_CYCLES = 4000;

   localparam int M_IDLE = 0, M_ARM = 1, M_DN = 2, M_UP = 3, M_STOP = 4, M_WAIT = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic auto_btn = 0, stop_btn = 0, reset_btn = 0;
   logic part_sense = 0, bottom_ls = 0, top_ls = 0;
   logic auto_lamp, part_hold, sol_up, sol_down;

   int checks = 0;
   int errors = 0;
   int model  = M_IDLE;

   always #(CLK_PERIOD/2) clk = ~clk;

   press_seq_ctrl u_dut (
      .clk(clk), .rst(rst), .auto_btn(auto_btn), .stop_btn(stop_btn),
      .reset_btn(reset_btn), .part_sense(part_sense), .bottom_ls(bottom_ls),
      .top_ls(top_ls), .auto_lamp(auto_lamp), .part_hold(part_hold),
      .sol_up(sol_up), .sol_down(sol_down)
   );

   function automatic int next_of(int s);
      int n = s;
      if (rst) return M_IDLE;
      case (s)
         M_IDLE: if (auto_btn)   n = M_ARM;
         M_ARM:  if (part_sense) n = M_DN;
         M_DN:   if (stop_btn) n = M_STOP; else if (bottom_ls) n = M_UP;
         M_UP:   if (top_ls)     n = M_WAIT;
         M_WAIT: if (!part_sense) n = M_ARM;
         M_STOP: if (reset_btn)  n = M_IDLE;
         default: n = M_IDLE;
      endcase
      return n;
   endfunction

   // order: lamp, hold, up, down
   function automatic logic [3:0] outs_of(int s);
      case (s)
         M_ARM:  return 4'b1000;
         M_DN:   return 4'b1101;
         M_UP:   return 4'b1110;
         M_WAIT: return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic string tag_of(int s);
      case (s)
         M_IDLE: return "R2";
         M_ARM:  return "R3";
         M_DN:   return "R4";
         M_UP:   return "R5";
         M_WAIT: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic compare(string tag);
      logic [3:0] act = {auto_lamp, part_hold, sol_up, sol_down};
      logic [3:0] exp = outs_of(model);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: outputs actual %b expected %b", tag, act, exp);
      end
      if (sol_up && sol_down) begin
         errors++;
         $display("FAIL R9: both solenoids actual 1 expected 0");
      end
   endtask

   // drive at negedge, clock, check at next negedge
   task automatic cyc(string tag, logic r, logic a, logic s, logic rb,
                      logic p, logic b, logic t);
      rst = r; auto_btn = a; stop_btn = s; reset_btn = rb;
      part_sense = p; bottom_ls = b; top_ls = t;
      @(posedge clk);
      model = next_of(model);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      cyc("R1", 1, 0, 0, 0, 0, 0, 0);
      cyc("R2", 0, 0, 1, 1, 1, 1, 1);   // idle ignores all but Auto
      cyc("R2", 0, 1, 0, 0, 0, 0, 0);   // armed
      cyc("R7", 0, 0, 1, 1, 0, 1, 1);   // stop ignored in armed (R3 too)
      cyc("R3", 0, 0, 0, 0, 1, 0, 0);   // down stroke
      cyc("R7", 0, 0, 1, 0, 1, 1, 0);   // stop beats bottom
      cyc("R8", 0, 1, 0, 0, 1, 0, 1);   // auto ignored in stopped
      cyc("R8", 0, 1, 1, 0, 1, 1, 1);
      cyc("R8", 0, 0, 0, 1, 0, 0, 0);   // reset -> idle
      cyc("R8", 0, 1, 0, 0, 0, 0, 0);   // auto arms again
      cyc("R3", 0, 0, 0, 0, 1, 0, 0);
      cyc("R4", 0, 0, 0, 0, 1, 1, 0);   // retract
      cyc("R7", 0, 0, 1, 0, 1, 0, 0);   // stop ignored in retract
      cyc("R5", 0, 0, 0, 0, 1, 0, 1);   // wait
      cyc("R6", 0, 0, 0, 0, 1, 0, 0);   // part still present: hold
      cyc("R6", 0, 0, 1, 1, 1, 1, 1);
      cyc("R6", 0, 0, 0, 0, 0, 0, 0);   // removed -> armed
      cyc("R3", 0, 0, 0, 0, 1, 0, 0);
      cyc("R1", 1, 0, 0, 0, 1, 0, 0);   // reset mid-stroke
      cyc("R2", 0, 0, 0, 0, 1, 0, 0);

      for (int i = 0; i < RAND_CYCLES; i++) begin
         logic r  = ($urandom % 97) == 0;
         logic a  = ($urandom % 4) == 0;
         logic s  = ($urandom % 6) == 0;
         logic rb = ($urandom % 4) == 0;
         logic p  = ($urandom % 2) == 0;
         logic b  = ($urandom % 3) == 0;
         logic t  = ($urandom % 3) == 0;
         string tg = r ? "R1" : ((s && model != M_DN) ? "R7" : tag_of(model));
         cyc(tg, r, a, s, rb, p, b, t);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule